// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock of an I2C master. Four programmable counts set the bus timing: a high count and a low count for standard mode, and another pair for fast mode. A single mode input picks which pair is in force. SCL is driven open-drain. The block only ever pulls the line low or releases it.

The low phase is timed from the cycle in which the block starts pulling the line. The high phase works differently. Its counter advances only on cycles where the synchronized line is seen high. A slave that holds SCL low after release therefore stretches the clock, and the counter waits at zero until the line really rises.

A transfer begins with a START request on an idle, high bus. The block pulls SDA low and holds it for a time derived from the high count, then starts the first low phase. The synchronizer depth and the minimum count are parameters. Byte shifting, acknowledge handling and arbitration belong to neighbouring logic.

The counts map to bus times with fixed offsets:

- Low phase: the low count plus one cycle. Because counting starts when the pull begins, the SCL fall time is included in this period.
- High phase: the high count plus eight cycles of overhead. The synchronizer latency is added on top, since the counter waits for the synchronized line.
- START hold: the high count plus three cycles.

Typical targets are 4.0 us high and 4.7 us low in standard mode, and 0.6 us high and 1.3 us low in fast mode.

Top module: `scl_period_gen`

## Requirements
- R1: After reset both `scl_pull` and `sda_start_pull` are 0, meaning both lines are released.
- R2: While `enable` is 0, `start_req` has no effect and `scl_pull` and `sda_start_pull` stay 0.
- R3: A `start_req` sampled with `enable` at 1 and the synchronized SCL high drives `sda_start_pull` to 1 from the next cycle. It stays at 1 for exactly Heff+3 cycles with SCL released, and `scl_pull` rises in the cycle in which it falls.
- R4: Every low phase keeps `scl_pull` at 1 for exactly Leff+1 cycles.
- R5: With no stretching, each high phase releases SCL for exactly SYNC_STAGES+Heff+8 cycles.
- R6: If SCL is held low externally for D cycles after release, the high counter stays at zero during that time. The released time then becomes D+SYNC_STAGES+Heff+8 cycles.
- R7: With `fast_mode`=1, Heff and Leff come from `fast_high_cnt` and `fast_low_cnt`. With `fast_mode`=0 they come from `std_high_cnt` and `std_low_cnt`.
- R8: Heff and Leff equal the selected count, except that a count below MIN_CNT (default 6) is replaced by MIN_CNT.
- R9: When `enable` is sampled at 0, both pulls are 0 from the next cycle and the generator returns to idle.
- R10: A `start_req` sampled while the synchronized SCL is low is ignored, so `sda_start_pull` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator runs while 1 |
| fast_mode | input | 1 | 1 selects the fast-mode count pair |
| start_req | input | 1 | Request to issue START and begin clocking |
| std_high_cnt | input | CNT_W | Standard-mode high count |
| std_low_cnt | input | CNT_W | Standard-mode low count |
| fast_high_cnt | input | CNT_W | Fast-mode high count |
| fast_low_cnt | input | CNT_W | Fast-mode low count |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_start_pull | output | 1 | 1 pulls SDA low for START hold |

## Verification
The bench builds the block with its defaults: CNT_W=16, MIN_CNT=6 and SYNC_STAGES=2. At these settings every phase length is a short, exactly countable number of cycles, so each phase can be measured against a closed-form value.

Small counts of 0, 2 and 3 reach the clamp. Identical count sets run in both modes, which shows that the mode input alone changes the timing.

A line model with a programmable stretch delay and an external hold-low covers the held-at-zero high counter and the refused START. Dropping `enable` in the middle of a low phase checks the release path.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_START = 2'd1,
      PH_LOW   = 2'd2,
      PH_HIGH  = 2'd3
   } phase_e;
endpackage

// File: rtl/scl_line_sync.sv
`timescale 1ns/1ps
module scl_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_seen
);
   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b1;
            else        q <= line_in;
         end
         assign line_seen = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else        q <= {q[STAGES-2:0], line_in};
         end
         assign line_seen = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/scl_count_select.sv
`timescale 1ns/1ps
module scl_count_select #(
   parameter int CNT_W   = 16,
   parameter int MIN_CNT = 6
) (
   input  logic             fast_mode,
   input  logic [CNT_W-1:0] std_high,
   input  logic [CNT_W-1:0] std_low,
   input  logic [CNT_W-1:0] fast_high,
   input  logic [CNT_W-1:0] fast_low,
   output logic [CNT_W-1:0] high_eff,
   output logic [CNT_W-1:0] low_eff
);
   logic [CNT_W-1:0] high_sel, low_sel;

   assign high_sel = fast_mode ? fast_high : std_high;
   assign low_sel  = fast_mode ? fast_low  : std_low;

   generate
      if (MIN_CNT > 0) begin : g_clamp
         localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);
         assign high_eff = (high_sel < FLOOR) ? FLOOR : high_sel;
         assign low_eff  = (low_sel  < FLOOR) ? FLOOR : low_sel;
      end else begin : g_pass
         assign high_eff = high_sel;
         assign low_eff  = low_sel;
      end
   endgenerate
endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
module scl_phase_fsm
   import scl_gen_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start_req,
   input  logic             scl_seen,
   input  logic [CNT_W-1:0] high_cnt,
   input  logic [CNT_W-1:0] low_cnt,
   output logic             scl_pull,
   output logic             sda_start_pull
);
   localparam int CW = CNT_W + 1;
   localparam int START_OVH = 3;
   localparam int HIGH_OVH  = 8;
   localparam int LOW_OVH   = 1;

   phase_e        phase_q, phase_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic [CW-1:0] start_last, high_last, low_last;

   assign start_last = {1'b0, high_cnt} + CW'(START_OVH - 1);
   assign high_last  = {1'b0, high_cnt} + CW'(HIGH_OVH - 1);
   assign low_last   = {1'b0, low_cnt}  + CW'(LOW_OVH - 1);

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      if (!enable) begin
         phase_d = PH_IDLE;
         cnt_d   = '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               cnt_d = '0;
               if (start_req && scl_seen) phase_d = PH_START;
            end
            PH_START: begin
               if (cnt_q == start_last) begin
                  phase_d = PH_LOW;
                  cnt_d   = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_LOW: begin
               if (cnt_q == low_last) begin
                  phase_d = PH_HIGH;
                  cnt_d   = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_HIGH: begin
               if (scl_seen) begin
                  if (cnt_q == high_last) begin
                     phase_d = PH_LOW;
                     cnt_d   = '0;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               phase_d = PH_IDLE;
               cnt_d   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign scl_pull       = (phase_q == PH_LOW);
   assign sda_start_pull = (phase_q == PH_START);
endmodule

// File: rtl/scl_period_gen.sv
`timescale 1ns/1ps
module scl_period_gen #(
   parameter int CNT_W       = 16,
   parameter int MIN_CNT     = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             fast_mode,
   input  logic             start_req,
   input  logic [CNT_W-1:0] std_high_cnt,
   input  logic [CNT_W-1:0] std_low_cnt,
   input  logic [CNT_W-1:0] fast_high_cnt,
   input  logic [CNT_W-1:0] fast_low_cnt,
   input  logic             scl_in,
   output logic             scl_pull,
   output logic             sda_start_pull
);
   generate
      if (CNT_W < 4 || CNT_W > 30) begin : g_bad_width
         $error("scl_period_gen: CNT_W out of range");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("scl_period_gen: SYNC_STAGES must be at least 1");
      end
      if (MIN_CNT < 0 || MIN_CNT >= (1 << CNT_W)) begin : g_bad_min
         $error("scl_period_gen: MIN_CNT does not fit CNT_W");
      end
   endgenerate

   logic             scl_seen;
   logic [CNT_W-1:0] high_eff, low_eff;

   scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (scl_in),
      .line_seen (scl_seen)
   );

   scl_count_select #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_sel (
      .fast_mode (fast_mode),
      .std_high  (std_high_cnt),
      .std_low   (std_low_cnt),
      .fast_high (fast_high_cnt),
      .fast_low  (fast_low_cnt),
      .high_eff  (high_eff),
      .low_eff   (low_eff)
   );

   scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .enable         (enable),
      .start_req      (start_req),
      .scl_seen       (scl_seen),
      .high_cnt       (high_eff),
      .low_cnt        (low_eff),
      .scl_pull       (scl_pull),
      .sda_start_pull (sda_start_pull)
   );
endmodule

// File: rtl/scl_period_gen_chk.sv
`timescale 1ns/1ps
module scl_period_gen_chk #(
   parameter int CNT_W   = 16,
   parameter int MIN_CNT = 6
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic start_req,
   input logic scl_in,
   input logic scl_pull,
   input logic sda_start_pull
);
   localparam int RW = CNT_W + 4;
   logic [RW-1:0] low_run, hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run <= '0;
         hi_run  <= '0;
      end else begin
         low_run <= scl_pull ? low_run + 1'b1 : '0;
         if (scl_pull)    hi_run <= '0;
         else if (scl_in) hi_run <= hi_run + 1'b1;
      end
   end

   // R9: disable releases both lines on the next cycle
   p_disable_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_pull && !sda_start_pull));

   // R3: START hold begins only from an accepted enabled request
   p_start_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_start_pull) |-> ($past(start_req) && $past(enable)));

   // R3: end of START hold hands over to a low phase
   p_hold_to_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_start_pull) && $past(enable)) |-> scl_pull);

   // R4: a completed low phase is never shorter than the clamped floor
   p_low_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_pull) && $past(enable)) |-> (low_run >= RW'(MIN_CNT + 1)));

   // R6: a new low phase after a high phase needs enough observed-high time
   p_high_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(scl_pull) && !$past(sda_start_pull) && $past(enable))
         |-> (hi_run >= RW'(MIN_CNT + 8)));
endmodule

bind scl_period_gen scl_period_gen_chk #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .enable         (enable),
   .start_req      (start_req),
   .scl_in         (scl_in),
   .scl_pull       (scl_pull),
   .sda_start_pull (sda_start_pull)
);

// File: tb/scl_period_gen_test.sv
`timescale 1ns/1ps
module scl_period_gen_test;
   localparam int CNT_W = 16;
   localparam int MINC  = 6;
   localparam int SYNC  = 2;

   typedef struct packed {
      logic        fast;
      logic [15:0] sh;
      logic [15:0] sl;
      logic [15:0] fh;
      logic [15:0] fl;
      logic [7:0]  stretch;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 16'd10, 16'd12, 16'd20, 16'd7, 8'd0},
      '{1'b1, 16'd10, 16'd12, 16'd20, 16'd7, 8'd0},
      '{1'b0, 16'd3,  16'd2,  16'd30, 16'd30, 8'd0},
      '{1'b0, 16'd9,  16'd8,  16'd2,  16'd2, 8'd5},
      '{1'b1, 16'd40, 16'd40, 16'd6,  16'd6, 8'd12},
      '{1'b1, 16'd11, 16'd11, 16'd0,  16'd0, 8'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, fast_mode = 1'b0, start_req = 1'b0;
   logic [CNT_W-1:0] sh = '0, sl = '0, fh = '0, fl = '0;
   logic scl_in, scl_pull, sda_start_pull;
   logic ext_low = 1'b0;
   logic prev_pull = 1'b0;
   int   stretch_cfg = 0;
   int   stretch_left = 0;
   int   n_checks = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   assign scl_in = !(scl_pull || (stretch_left != 0) || ext_low);

   always @(negedge clk) begin
      if (prev_pull && !scl_pull && stretch_cfg > 0) stretch_left <= stretch_cfg;
      else if (stretch_left > 0)                     stretch_left <= stretch_left - 1;
      prev_pull <= scl_pull;
   end

   scl_period_gen #(.CNT_W(CNT_W), .MIN_CNT(MINC), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
      .start_req(start_req), .std_high_cnt(sh), .std_low_cnt(sl),
      .fast_high_cnt(fh), .fast_low_cnt(fl), .scl_in(scl_in),
      .scl_pull(scl_pull), .sda_start_pull(sda_start_pull)
   );

   function automatic int eff(input int c);
      return (c < MINC) ? MINC : c;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic measure(input bit on_sda, input logic val, output int n);
      n = 0;
      while (((on_sda ? sda_start_pull : scl_pull) == val) && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start_req = 1'b1;
      @(negedge clk) start_req = 1'b0;
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 scl_pull", int'(scl_pull), 0);
      check("R1 sda_start_pull", int'(sda_start_pull), 0);
      rst_n = 1'b1;
      sh = 16'd10; sl = 16'd10;
      repeat (3) @(negedge clk);

      // R2: start ignored while disabled
      pulse_start();
      for (int i = 0; i < 4; i++) begin
         check("R2 sda while disabled", int'(sda_start_pull), 0);
         check("R2 scl while disabled", int'(scl_pull), 0);
         @(negedge clk);
      end

      // Vector walk: R3 R4 R5 R6 R7 R8
      for (int v = 0; v < 6; v++) begin
         int h_eff, l_eff, d;
         fast_mode = VECS[v].fast;
         sh = VECS[v].sh; sl = VECS[v].sl;
         fh = VECS[v].fh; fl = VECS[v].fl;
         d  = int'(VECS[v].stretch);
         stretch_cfg = d;
         h_eff = eff(int'(VECS[v].fast ? VECS[v].fh : VECS[v].sh));
         l_eff = eff(int'(VECS[v].fast ? VECS[v].fl : VECS[v].sl));
         enable = 1'b1;
         @(negedge clk);
         pulse_start();
         measure(1'b1, 1'b1, n);
         check($sformatf("R3/R7/R8 start hold v%0d", v), n, h_eff + 3);
         measure(1'b0, 1'b1, n);
         check($sformatf("R4/R7/R8 first low v%0d", v), n, l_eff + 1);
         measure(1'b0, 1'b0, n);
         check($sformatf("R5/R6 released v%0d", v), n, d + SYNC + h_eff + 8);
         measure(1'b0, 1'b1, n);
         check($sformatf("R4 second low v%0d", v), n, l_eff + 1);
         enable = 1'b0;
         stretch_cfg = 0;
         repeat (d + 4) @(negedge clk);
      end

      // R10: start refused while the line is held low
      stretch_cfg = 0;
      sh = 16'd10; sl = 16'd10; fast_mode = 1'b0;
      enable = 1'b1;
      ext_low = 1'b1;
      repeat (4) @(negedge clk);
      pulse_start();
      for (int i = 0; i < 4; i++) begin
         check("R10 sda stays released", int'(sda_start_pull), 0);
         @(negedge clk);
      end
      ext_low = 1'b0;
      repeat (4) @(negedge clk);

      // R9: disable in the middle of a low phase
      pulse_start();
      measure(1'b1, 1'b1, n);
      check("R9 pre start hold", n, 13);
      repeat (3) @(negedge clk);
      check("R9 pull active mid low", int'(scl_pull), 1);
      enable = 1'b0;
      @(negedge clk);
      check("R9 scl released", int'(scl_pull), 0);
      check("R9 sda released", int'(sda_start_pull), 0);
      repeat (3) @(negedge clk);
      check("R9 stays idle", int'(scl_pull), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule